// File: doc/BRIEF.md
# Triggered Programmable Pulse Timer

This peripheral sits on an 8-bit processor bus. A rising edge on an external trigger pin starts a delay interval. When the delay expires the block drives its output high for a programmed width and then drops it again. Software sets the delay and the width as 16-bit tick counts. It also picks the time base: either a shared one-cycle microsecond strobe, or the rising edges of an external clock pin that is synchronized into the system clock domain.

The interrupt output is a one-cycle strobe. Software chooses which event raises it: the trigger being accepted, the output rising, or the output falling. Software can also switch it off. Register writes land only while the write-qualification input is high, so a protection scheme higher up can lock the block. Read data appears one cycle after a read strobe. The bus has no data stream, so all pins are plain control and status signals with no valid/ready handshake.

Register map (byte offsets on `bus_addr`):

| Offset | Access | Contents |
|---|---|---|
| 0 | read/write | delay, low byte (staged) |
| 1 | read/write | delay, high byte (writing it commits the delay) |
| 2 | read/write | width, low byte (staged) |
| 3 | read/write | width, high byte (writing it commits the width) |
| 4 | read/write | control: bits [1:0] interrupt source (00 trigger, 01 output rising, 10 output falling, 11 off); bit 2 time base (0 microsecond strobe, 1 external clock) |
| 5 | read only | status: bit 0 busy, bit 1 output level |
| 6, 7 | — | read 0; writes ignored |

Top module: `trig_pulse_timer`

## Requirements
- R1: After reset, `pulse_out`, `irq` and `rd_data` are 0. Delay, width and control all read back 0, and the status register reads 0.
- R2: Delay sits at offsets 0 (low byte) and 1 (high byte). Width sits at offsets 2 (low) and 3 (high). A low-byte write is staged and does not change the readback value. Writing the high byte commits `{high, staged low}` as the new 16-bit value.
- R3: While `wr_qual` is 0, a write to any offset leaves every register unchanged.
- R4: With delay D, the output rises on the (D+1)-th time-base tick after the trigger is accepted. A delay of 0 therefore rises on the first tick.
- R5: With width W greater than 0, the output stays high for exactly W ticks and then returns low. With W = 0, no pulse occurs, no edge interrupt is raised, and the block returns to idle on the tick that ends the delay.
- R6: Control bits [1:0] select the interrupt source: 00 trigger accepted, 01 output rising, 10 output falling, 11 none. Each selected event gives one `irq` pulse exactly one clock long.
- R7: With control bit 2 at 0, the time base is `usec_tick` and `ext_clk` is ignored. With bit 2 at 1, each synchronized rising edge of `ext_clk` is one tick and `usec_tick` is ignored.
- R8: A trigger rising edge that arrives while a delay or pulse is in progress is ignored. It neither restarts the timing nor raises a trigger interrupt.
- R9: The status register at offset 5 returns busy (delay or pulse in progress) in bit 0 and the current output level in bit 1.
- R10: `rd_data` holds the addressed register in the cycle after a clock edge that samples `bus_rd` high. After an edge with `bus_rd` low, it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| usec_tick | input | 1 | Shared one-cycle microsecond strobe |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read enable |
| wr_qual | input | 1 | Write qualification; writes land only while high |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | One-cycle interrupt strobe |
| trig_in | input | 1 | Asynchronous trigger; rising edge starts a cycle |
| ext_clk | input | 1 | Asynchronous external time base |
| pulse_out | output | 1 | Timed output pulse |

## Verification
The bench builds the block with its default parameters: 3 address bits and a 2-flop synchronizer. The counters are therefore the full 16 bits, so a committed value whose high byte is nonzero produces counts above 255. The tick strobe is driven directly by the bench, so every count can be checked tick by tick. This makes the zero-delay and zero-width corners reachable with few cycles, along with counts that cross the byte boundary. The external-clock path is exercised with slow periods, which leave room for the synchronizer latency.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  localparam logic [2:0] OFS_DLY_LO = 3'd0;
  localparam logic [2:0] OFS_DLY_HI = 3'd1;
  localparam logic [2:0] OFS_WID_LO = 3'd2;
  localparam logic [2:0] OFS_WID_HI = 3'd3;
  localparam logic [2:0] OFS_CTRL   = 3'd4;
  localparam logic [2:0] OFS_STAT   = 3'd5;

  typedef enum logic [1:0] {
    SRC_TRIG = 2'b00,
    SRC_RISE = 2'b01,
    SRC_FALL = 2'b10,
    SRC_NONE = 2'b11
  } irq_src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PULSE = 2'd2
  } tpt_state_e;
endpackage

// File: rtl/tpt_sync_edge.sv
module tpt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tpt_regs.sv
module tpt_regs
  import tpt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              wr_qual,
  input  logic              busy,
  input  logic              level,
  output logic [CNT_W-1:0]  delay_val,
  output logic [CNT_W-1:0]  width_val,
  output irq_src_e          irq_src,
  output logic              ext_base,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] dly_stage_q, wid_stage_q;
  logic [CNT_W-1:0]  dly_q, wid_q;
  logic [2:0]        ctrl_q;
  logic              wr_ok;
  logic [2:0]        ofs;
  logic [BYTE_W-1:0] rd_mux;

  assign wr_ok = bus_wr & wr_qual;
  assign ofs   = 3'(bus_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_stage_q <= '0;
      wid_stage_q <= '0;
      dly_q       <= '0;
      wid_q       <= '0;
      ctrl_q      <= '0;
    end else if (wr_ok) begin
      case (ofs)
        OFS_DLY_LO: dly_stage_q <= bus_wdata;
        OFS_DLY_HI: dly_q       <= {bus_wdata, dly_stage_q};
        OFS_WID_LO: wid_stage_q <= bus_wdata;
        OFS_WID_HI: wid_q       <= {bus_wdata, wid_stage_q};
        OFS_CTRL:   ctrl_q      <= bus_wdata[2:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ofs)
      OFS_DLY_LO: rd_mux = dly_q[BYTE_W-1:0];
      OFS_DLY_HI: rd_mux = dly_q[CNT_W-1:BYTE_W];
      OFS_WID_LO: rd_mux = wid_q[BYTE_W-1:0];
      OFS_WID_HI: rd_mux = wid_q[CNT_W-1:BYTE_W];
      OFS_CTRL:   rd_mux = {{(BYTE_W-3){1'b0}}, ctrl_q};
      OFS_STAT:   rd_mux = {{(BYTE_W-2){1'b0}}, level, busy};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (bus_rd) rd_data <= rd_mux;
    else             rd_data <= '0;
  end

  assign delay_val = dly_q;
  assign width_val = wid_q;
  assign irq_src   = irq_src_e'(ctrl_q[1:0]);
  assign ext_base  = ctrl_q[2];

  AST_UNQUAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_ok |=> ($stable(dly_q) && $stable(wid_q) && $stable(ctrl_q))); // R3
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (rd_data == '0)); // R10
endmodule

// File: rtl/tpt_engine.sv
module tpt_engine
  import tpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_rise,
  input  logic             tick,
  input  logic [CNT_W-1:0] delay_val,
  input  logic [CNT_W-1:0] width_val,
  input  irq_src_e         irq_src,
  output logic             busy,
  output logic             pulse_q,
  output logic             irq_q
);
  tpt_state_e       st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      pulse_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (trig_rise) begin
            st  <= ST_DELAY;
            cnt <= delay_val;
            if (irq_src == SRC_TRIG) irq_q <= 1'b1;
          end
        end
        ST_DELAY: begin
          if (tick) begin
            if (cnt == '0) begin
              if (width_val == '0) begin
                st <= ST_IDLE;
              end else begin
                st      <= ST_PULSE;
                cnt     <= width_val;
                pulse_q <= 1'b1;
                if (irq_src == SRC_RISE) irq_q <= 1'b1;
              end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        ST_PULSE: begin
          if (tick) begin
            if (cnt <= CNT_W'(1)) begin
              st      <= ST_IDLE;
              pulse_q <= 1'b0;
              if (irq_src == SRC_FALL) irq_q <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE);

  AST_IRQ_STROBE: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q); // R6
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_q) |-> ($past(tick) && $past(st) == ST_DELAY)); // R4
  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_q) |-> $past(tick)); // R5
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DELAY && !tick) |=> (st == ST_DELAY && $stable(cnt))); // R8
endmodule

// File: rtl/trig_pulse_timer.sv
module trig_pulse_timer
  import tpt_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              usec_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  input  logic              wr_qual,
  output logic [7:0]        rd_data,
  output logic              irq,
  input  logic              trig_in,
  input  logic              ext_clk,
  output logic              pulse_out
);
  localparam int N_SYNC = 2;

  logic [N_SYNC-1:0] raw_in, rise_v;
  logic [CNT_W-1:0]  delay_val, width_val;
  irq_src_e          irq_src;
  logic              ext_base, busy, tick;

  assign raw_in = {ext_clk, trig_in};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    tpt_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
      .clk (clk),
      .rst (rst),
      .din (raw_in[g]),
      .rise(rise_v[g])
    );
  end

  assign tick = ext_base ? rise_v[1] : usec_tick;

  tpt_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .wr_qual  (wr_qual),
    .busy     (busy),
    .level    (pulse_out),
    .delay_val(delay_val),
    .width_val(width_val),
    .irq_src  (irq_src),
    .ext_base (ext_base),
    .rd_data  (rd_data)
  );

  tpt_engine engine_i (
    .clk      (clk),
    .rst      (rst),
    .trig_rise(rise_v[0]),
    .tick     (tick),
    .delay_val(delay_val),
    .width_val(width_val),
    .irq_src  (irq_src),
    .busy     (busy),
    .pulse_q  (pulse_out),
    .irq_q    (irq)
  );

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !pulse_out); // R5
endmodule

// File: tb/trig_pulse_timer_tb_top.sv
module trig_pulse_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       usec_tick = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic       wr_qual = 1'b1;
  logic [7:0] rd_data;
  logic       irq;
  logic       trig_in = 1'b0;
  logic       ext_clk = 1'b0;
  logic       pulse_out;

  int n_chk = 0;
  int n_err = 0;
  int irq_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trig_pulse_timer dut_i (
    .clk(clk), .rst(rst), .usec_tick(usec_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .wr_qual(wr_qual),
    .rd_data(rd_data), .irq(irq), .trig_in(trig_in), .ext_clk(ext_clk),
    .pulse_out(pulse_out)
  );

  always @(posedge clk) if (!rst && irq) irq_cnt <= irq_cnt + 1;

  // {delay[15:0], width[15:0], irq source[1:0]}
  localparam int NV = 7;
  localparam logic [33:0] VEC [NV] = '{
    {16'd0,      16'd1,      2'b00},
    {16'd2,      16'd3,      2'b01},
    {16'd1,      16'd0,      2'b01},
    {16'd3,      16'd2,      2'b10},
    {16'd0,      16'd0,      2'b00},
    {16'd1,      16'd2,      2'b11},
    {16'h0102,   16'h0101,   2'b10}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic q);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; wr_qual = q;
    @(negedge clk);
    bus_wr = 1'b0; wr_qual = 1'b1;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic tick();
    @(negedge clk); usec_tick = 1'b1;
    @(negedge clk); usec_tick = 1'b0;
  endtask

  task automatic ext_period();
    @(negedge clk); ext_clk = 1'b1;
    repeat (4) @(negedge clk);
    ext_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic trig();
    @(negedge clk); trig_in = 1'b1;
    repeat (4) @(negedge clk);
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] d, input logic [15:0] w, input logic [2:0] c);
    wr(3'd0, d[7:0], 1'b1); wr(3'd1, d[15:8], 1'b1);
    wr(3'd2, w[7:0], 1'b1); wr(3'd3, w[15:8], 1'b1);
    wr(3'd4, {5'd0, c}, 1'b1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int v, v2, rise_at, highs, base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pulse_out", int'(pulse_out), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    rd(3'd5, v); chk("R1 status", v, 0);
    rd(3'd1, v); chk("R1 delay hi", v, 0);
    rd(3'd4, v); chk("R1 control", v, 0);

    // Table walk: R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      logic [15:0] d, w;
      logic [1:0]  s;
      int exp_irq;
      {d, w, s} = VEC[i];
      setup(d, w, {1'b0, s});
      base = irq_cnt;
      trig();
      rd(3'd5, v); chk("R9 busy after trigger", v, 1);
      rise_at = 0; highs = 0;
      for (int t = 1; t <= int'(d) + int'(w) + 3; t++) begin
        tick();
        if (pulse_out) begin
          highs++;
          if (rise_at == 0) rise_at = t;
          if (t == int'(d) + 1) begin
            rd(3'd5, v); chk("R9 status level", v, 3);
          end
        end
      end
      chk("R4 rise tick", rise_at, (w == 0) ? 0 : int'(d) + 1);
      chk("R5 high ticks", highs, int'(w));
      case (s)
        2'b00:   exp_irq = 1;
        2'b01,
        2'b10:   exp_irq = (w == 0) ? 0 : 1;
        default: exp_irq = 0;
      endcase
      chk("R6 irq count", irq_cnt - base, exp_irq);
      rd(3'd5, v); chk("R9 idle status", v, 0);
    end

    // R3 unqualified writes ignored (delay is 0x0102 from the table)
    wr(3'd0, 8'h55, 1'b0); wr(3'd1, 8'hAA, 1'b0); wr(3'd4, 8'h07, 1'b0);
    rd(3'd0, v); chk("R3 delay lo held", v, 8'h02);
    rd(3'd1, v); chk("R3 delay hi held", v, 8'h01);
    rd(3'd4, v); chk("R3 control held", v, 2);

    // R2 low byte staged until high byte written
    wr(3'd0, 8'h34, 1'b1);
    rd(3'd0, v); chk("R2 lo staged", v, 8'h02);
    wr(3'd1, 8'h12, 1'b1);
    rd(3'd0, v); rd(3'd1, v2);
    chk("R2 committed", v2 * 256 + v, 16'h1234);

    // R10 rd_data zero after read strobe drops
    @(negedge clk); chk("R10 rd_data idle", int'(rd_data), 0);

    // R8 retrigger during delay is ignored
    setup(16'd3, 16'd2, 3'b000);
    base = irq_cnt;
    trig();
    tick();
    trig();
    rise_at = 0;
    for (int t = 2; t <= 7; t++) begin
      tick();
      if (pulse_out && rise_at == 0) rise_at = t;
    end
    chk("R8 rise unaffected", rise_at, 4);
    chk("R8 single trigger irq", irq_cnt - base, 1);

    // R7 external time base, usec_tick ignored
    setup(16'd1, 16'd2, 3'b101);
    base = irq_cnt;
    trig();
    repeat (5) tick();
    chk("R7 usec ignored", int'(pulse_out), 0);
    rd(3'd5, v); chk("R7 still busy", v, 1);
    ext_period();
    chk("R7 one ext edge", int'(pulse_out), 0);
    ext_period();
    chk("R7 rise on 2nd edge", int'(pulse_out), 1);
    chk("R6 rise irq", irq_cnt - base, 1);
    ext_period();
    chk("R7 high after 3rd edge", int'(pulse_out), 1);
    ext_period();
    chk("R7 low after 4th edge", int'(pulse_out), 0);

    done = 1;
    finish_run();
  end
endmodule